// File: doc/BRIEF.md
# Byte-Swapping IDE Register Window

This block sits between a big-endian host bus and an IDE task-file register interface. It takes a 4 KB memory-mapped window in which each IDE register occupies its own 16-byte slot. It decodes each host access into a single-cycle request on the IDE side. Byte accesses reach the seven task-file registers, or the combined control/status register through either of two slot aliases. Half-word and word accesses reach only the data register.

Data passing through the data register is byte-reversed in both directions. A big-endian host therefore reads and writes little-endian drive data in its natural order. A slot that decodes to nothing returns all ones, at the width of the access, and swallows writes without any IDE-side activity. Read data is registered and comes back one cycle after the request, marked by a valid pulse.

Top module: `ide_swap_window`

## Requirements
- R1: The register slot index is address bits [11:4]. Address bits [3:0] do not affect decoding. Access size codes on `size_i` are 0 = byte, 1 = half-word (16 bits), 2 = word (32 bits) and 3 = reserved.
- R2: A byte access to slot 1 through 7 asserts `ide_stb_o` with `ide_ctl_o` = 0 and `ide_idx_o` equal to the slot number. A write presents `wdata_i[7:0]` on `ide_wdata_o[7:0]` with zero upper bits. A read returns `ide_rdata_i[7:0]` zero-extended.
- R3: A byte access to slot 8 or slot 22 asserts `ide_stb_o` with `ide_ctl_o` = 1 and `ide_idx_o` = 0. In this state a write targets device control and a read returns status, which is `ide_rdata_i[7:0]` zero-extended.
- R4: A byte access to any other slot, slot 0 included, leaves `ide_stb_o` low. A read of such a slot returns 0x000000FF.
- R5: Half-word and word accesses decode only at slot 0, the data register. They assert `ide_stb_o` with `ide_idx_o` = 0 and `ide_ctl_o` = 0, and `ide_wide_o` = 1 for a word access. At any other slot they leave `ide_stb_o` low and read 0x0000FFFF (half) or 0xFFFFFFFF (word). Reserved-size accesses never strobe and read 0xFFFFFFFF.
- R6: For a half-word data access, the two low bytes are swapped in both directions. A write sends {wdata_i[7:0], wdata_i[15:8]} on the low 16 bits. A read returns {ide_rdata_i[7:0], ide_rdata_i[15:8]} on the low 16 bits. Upper bits are zero in both cases.
- R7: For a word data access, all four bytes are reversed in both directions. Byte 0 swaps with byte 3, and byte 1 swaps with byte 2.
- R8: `ide_stb_o` is high only in a cycle where `req_i` is high and the access decodes to a register, so each request gives exactly one strobe cycle.
- R9: `rvalid_o` pulses in the cycle after each read request (`req_i` high, `we_i` low), with the read data on `rdata_o`. It stays low after writes and after idle cycles.
- R10: While `rst_ni` is low, `rvalid_o` and `rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| addr_i | input | 12 | Byte address inside the window |
| wdata_i | input | 32 | Host write data, right-justified |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| ide_stb_o | output | 1 | IDE register access strobe |
| ide_we_o | output | 1 | IDE access direction |
| ide_ctl_o | output | 1 | Selects the control/status register |
| ide_idx_o | output | 3 | Task-file register number, 0 for the data register |
| ide_wide_o | output | 1 | Data access is 32 bits wide |
| ide_wdata_o | output | 32 | Write data toward the drive, already swapped |
| ide_rdata_i | input | 32 | Read data from the drive, little-endian |

## Verification
The bench targets the decode boundaries: slot 0 with a byte access, slot 9 and slot 21 around the two control/status aliases, and slot 1 with a half-word access. A decoder with an off-by-one or a missing alias would strobe the drive on an unmapped slot, or return all ones from a live register. Data-register accesses use asymmetric byte patterns in both directions, so a missing swap, a swap on the wrong half, or a half-word swap applied to a word would show as a miscompare. Unmapped reads of each size check the width of the all-ones value. Writes to unmapped slots are checked for the absence of any strobe.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_TASKFILE,
    TGT_CTLSTAT,
    TGT_DATA
  } tgt_e;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int TF_LAST  = 7,
  parameter int CS_IDX_A = 8,
  parameter int CS_IDX_B = 22
) (
  input  acc_size_e        size_i,
  input  logic [IDX_W-1:0] idx_i,
  output tgt_e             tgt_o
);
  localparam logic [IDX_W-1:0] TF_HI = IDX_W'(TF_LAST);
  localparam logic [IDX_W-1:0] CS_A  = IDX_W'(CS_IDX_A);
  localparam logic [IDX_W-1:0] CS_B  = IDX_W'(CS_IDX_B);

  always_comb begin
    tgt_o = TGT_NONE;
    unique case (size_i)
      SZ_BYTE: begin
        if (idx_i != '0 && idx_i <= TF_HI)      tgt_o = TGT_TASKFILE;
        else if (idx_i == CS_A || idx_i == CS_B) tgt_o = TGT_CTLSTAT;
      end
      SZ_HALF, SZ_WORD: if (idx_i == '0) tgt_o = TGT_DATA;
      default: tgt_o = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap
  import ide_win_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  localparam int NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_WORD: d_o[8*b +: 8] = d_i[8*(NB-1-b) +: 8];
        SZ_HALF: d_o[8*b +: 8] = (b < 2) ? d_i[8*(1-b) +: 8] : 8'h00;
        default: d_o[8*b +: 8] = (b == 0) ? d_i[7:0] : 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/ide_win_rsp.sv
module ide_win_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_data_i;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o) else $error("rvalid missing");  // R9
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o) else $error("spurious rvalid");  // R9
endmodule

// File: rtl/ide_swap_window.sv
module ide_swap_window
  import ide_win_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int STRIDE_LG = 4,
  parameter int DATA_W    = 32,
  parameter int REG_W     = 3,
  parameter int CS_IDX_A  = 8,
  parameter int CS_IDX_B  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              ide_stb_o,
  output logic              ide_we_o,
  output logic              ide_ctl_o,
  output logic [REG_W-1:0]  ide_idx_o,
  output logic              ide_wide_o,
  output logic [DATA_W-1:0] ide_wdata_o,
  input  logic [DATA_W-1:0] ide_rdata_i
);
  localparam int IDX_W   = ADDR_W - STRIDE_LG;
  localparam int TF_LAST = (1 << REG_W) - 1;

  acc_size_e         size;
  logic [IDX_W-1:0]  idx;
  tgt_e              tgt;
  logic              mapped;
  logic [DATA_W-1:0] rd_swapped, rd_ones, rd_val;

  assign size = acc_size_e'(size_i);
  assign idx  = addr_i[ADDR_W-1:STRIDE_LG];

  ide_win_decode #(
    .IDX_W(IDX_W), .TF_LAST(TF_LAST), .CS_IDX_A(CS_IDX_A), .CS_IDX_B(CS_IDX_B)
  ) u_decode (
    .size_i(size), .idx_i(idx), .tgt_o(tgt)
  );

  ide_win_swap #(.DATA_W(DATA_W)) u_wswap (
    .size_i(size), .d_i(wdata_i), .d_o(ide_wdata_o)
  );

  ide_win_swap #(.DATA_W(DATA_W)) u_rswap (
    .size_i(size), .d_i(ide_rdata_i), .d_o(rd_swapped)
  );

  assign mapped     = (tgt != TGT_NONE);
  assign ide_stb_o  = req_i & mapped;
  assign ide_we_o   = we_i;
  assign ide_ctl_o  = (tgt == TGT_CTLSTAT);
  assign ide_idx_o  = (tgt == TGT_TASKFILE) ? idx[REG_W-1:0] : '0;
  assign ide_wide_o = (size == SZ_WORD);

  // all-ones at the access width
  always_comb begin
    unique case (size)
      SZ_BYTE: rd_ones = DATA_W'(8'hFF);
      SZ_HALF: rd_ones = DATA_W'(16'hFFFF);
      default: rd_ones = '1;
    endcase
  end

  assign rd_val = mapped ? rd_swapped : rd_ones;

  ide_win_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(req_i & ~we_i),
    .rd_data_i(rd_val), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  AST_WIDE_ONLY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ide_stb_o && size_i != 2'd0) |-> (ide_idx_o == '0 && !ide_ctl_o && idx == '0))
    else $error("wide access off data slot");  // R5
  AST_BYTE_SLOT0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd0 && idx == '0) |-> !ide_stb_o)
    else $error("byte strobe at slot 0");  // R4
  AST_UNMAPPED_BYTE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0 && !ide_stb_o) |=> (rdata_o == DATA_W'(8'hFF)))
    else $error("unmapped byte read not 0xFF");  // R4
  AST_CTL_IS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ide_stb_o && ide_ctl_o) |-> (size_i == 2'd0 && (idx == IDX_W'(CS_IDX_A) || idx == IDX_W'(CS_IDX_B))))
    else $error("control alias misdecoded");  // R3
  AST_STB_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !ide_stb_o) else $error("strobe without request");  // R8
endmodule

// File: tb/ide_swap_window_bench.sv
`timescale 1ns/1ps
module ide_swap_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, ide_rdata = '0;
  logic [31:0] rdata, ide_wdata;
  logic        rvalid, ide_stb, ide_we, ide_ctl, ide_wide;
  logic [2:0]  ide_idx;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ide_swap_window u_ide_swap_window (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .ide_stb_o(ide_stb), .ide_we_o(ide_we), .ide_ctl_o(ide_ctl),
    .ide_idx_o(ide_idx), .ide_wide_o(ide_wide), .ide_wdata_o(ide_wdata),
    .ide_rdata_i(ide_rdata)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] rev16(input logic [31:0] d);
    return {16'h0, d[7:0], d[15:8]};
  endfunction
  function automatic logic [31:0] rev32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // kind: 0 none, 1 task-file, 2 ctl/status, 3 data
  function automatic int kind_of(input logic [1:0] sz, input logic [11:0] a);
    logic [7:0] s = a[11:4];
    if (sz == 2'd0) begin
      if (s >= 1 && s <= 7) return 1;
      if (s == 8 || s == 22) return 2;
      return 0;
    end
    if ((sz == 2'd1 || sz == 2'd2) && s == 0) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [11:0] a,
                                         input logic [31:0] d);
    if (kind_of(sz, a) == 0) return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (sz == 2'd0) return {24'h0, d[7:0]};
    if (sz == 2'd1) return rev16(d);
    return rev32(d);
  endfunction

  task automatic access(input string r, input logic w, input logic [1:0] sz,
                        input logic [11:0] a, input logic [31:0] d);
    int k = kind_of(sz, a);
    @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = a;
    if (w) wdata = d; else ide_rdata = d;
    #1;
    check({r, " strobe"}, {31'h0, ide_stb}, {31'h0, k != 0});
    if (k != 0) begin
      check({r, " ctl"}, {31'h0, ide_ctl}, {31'h0, k == 2});
      check({r, " idx"}, {29'h0, ide_idx}, (k == 1) ? {24'h0, a[11:4]} : 32'h0);
      check({r, " wide"}, {31'h0, ide_wide}, {31'h0, sz == 2'd2});
      if (w) check({r, " wdata"}, ide_wdata,
                   (sz == 2'd0) ? {24'h0, d[7:0]} : (sz == 2'd1) ? rev16(d) : rev32(d));
    end
    if (!w) begin
      exp_q.push_back(exp_rd(sz, a, d));
      tag_q.push_back(r);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (exp_q.size() == 0) check("R9 unexpected rvalid", 32'h1, 32'h0);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check({t, " rdata"}, rdata, e);
        end
      end else if (exp_q.size() != 0) begin
        check({tag_q[0], " R9 rvalid"}, 32'h0, 32'h1);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R10 reset rvalid", {31'h0, rvalid}, 32'h0);
    check("R10 reset rdata", rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access("R2 tf read slot1", 1'b0, 2'd0, 12'h010, 32'hAABB_CC5A);
    access("R2 tf write slot7", 1'b1, 2'd0, 12'h07C, 32'h1234_56E3);
    access("R1 low bits ignored slot3", 1'b0, 2'd0, 12'h03F, 32'h0000_0071);
    access("R3 ctl read slot8", 1'b0, 2'd0, 12'h080, 32'hFFFF_FF50);
    access("R3 ctl write alias22", 1'b1, 2'd0, 12'h160, 32'h0000_0004);
    access("R3 status read alias22", 1'b0, 2'd0, 12'h163, 32'h0000_0058);
    access("R4 byte slot0 read", 1'b0, 2'd0, 12'h000, 32'h0000_0012);
    access("R4 byte slot9 read", 1'b0, 2'd0, 12'h090, 32'h0000_0034);
    access("R4 byte slot21 write", 1'b1, 2'd0, 12'h150, 32'h0000_0099);
    access("R4 byte slot255 read", 1'b0, 2'd0, 12'hFF0, 32'h0000_0011);
    access("R6 half write data", 1'b1, 2'd1, 12'h000, 32'h0000_A1B2);
    access("R6 half read data", 1'b0, 2'd1, 12'h002, 32'h9988_C3D4);
    access("R7 word write data", 1'b1, 2'd2, 12'h000, 32'h0102_0304);
    access("R7 word read data", 1'b0, 2'd2, 12'h000, 32'hDEAD_BEEF);
    idle();
    access("R5 half slot1 read", 1'b0, 2'd1, 12'h010, 32'h5555_1234);
    access("R5 word slot2 read", 1'b0, 2'd2, 12'h020, 32'h0);
    access("R5 word slot1 write", 1'b1, 2'd2, 12'h010, 32'hCAFE_F00D);
    access("R5 rsvd slot0 read", 1'b0, 2'd3, 12'h000, 32'h1111_2222);
    access("R8 rsvd write", 1'b1, 2'd3, 12'h000, 32'h3333_4444);
    idle();
    #1;
    check("R8 idle no strobe", {31'h0, ide_stb}, 32'h0);
    idle();
    #1;
    check("R9 idle no rvalid", {31'h0, rvalid}, 32'h0);
    idle();
    idle();
    check("R9 queue drained", exp_q.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule